// File: doc/BRIEF.md
# Banked Bit-Set Read-Modify-Write Unit

This unit carries out a single-bit set on one byte of a data-memory register file, driven by a four-phase instruction cycle that it sequences itself: one clock per phase, in the order decode, read, modify, write. In the decode phase it takes the 16-bit instruction word and extracts the bit number, the access flag and the 8-bit file address. It also captures the current bank select value, the extended-mode enable and the index register. From these it forms a 12-bit effective address.

The effective address comes from one of three schemes. Banked mode places the bank select value above the file address. Access mode folds the file address into either the bottom bank or the top bank. Indexed mode, which applies only when extended mode is on and the file address is small, adds the file address to the index register. The byte is read through a synchronous register-file port in the read phase. The selected bit is ORed in during the modify phase, and the result is written back to the same address in the write phase. No flags are produced, and any instruction word that is not the bit-set opcode leaves memory untouched.

Top module: `bsf_rmw_unit`

## Requirements
- R1: Out of reset the phase output is one-hot Q1 (`0001`), and each clock advances it Q1→Q2 (`0010`)→Q3 (`0100`)→Q4 (`1000`)→Q1 with no other value ever appearing.
- R2: An instruction is the bit-set operation only when bits 15:12 of the word equal `1000`. In that case bits 11:9 are the bit number, bit 8 is the access flag and bits 7:0 are the file address.
- R3: `rf_rd` is high only in the Q2 phase, and only when the word captured in Q1 is the bit-set opcode.
- R4: `rf_wr` is high only in the Q4 phase, and only for the bit-set opcode. Any other word causes neither a read nor a write.
- R5: The byte written is the byte read with the selected bit forced to 1 and all other bits unchanged (for example 0x0A with bit 7 gives 0x8A). A bit that is already set produces an unchanged byte.
- R6: With the access flag at 1, the address is {bank[3:0], f}, whatever the extended-mode setting.
- R7: With the access flag at 0 and indexed mode not selected, f below 0x80 gives address 0x000|f and f of 0x80 or above gives 0xF00|f.
- R8: With the access flag at 0, extended mode on and f ≤ 0x5F, the address is (index + f) modulo 4096. f = 0x60 falls back to the R7 mapping.
- R9: Bank, index and extended-mode inputs are sampled in Q1 only. The address presented in Q4 equals the one in Q2 even if those inputs change in between.
- R10: While reset is high, neither `rf_rd` nor `rf_wr` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, one edge per Q phase |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Instruction word, sampled at the end of Q1 |
| bank_sel | input | 4 | Bank select value, sampled at the end of Q1 |
| ext_en | input | 1 | Extended-mode enable, sampled at the end of Q1 |
| index_base | input | 12 | Index register for literal-offset mode, sampled at the end of Q1 |
| qphase | output | 4 | One-hot current phase (bit 0 = Q1 … bit 3 = Q4) |
| rf_addr | output | 12 | Register-file address |
| rf_rd | output | 1 | Read strobe; data returns in the following cycle |
| rf_rdata | input | 8 | Registered read data from the register file |
| rf_wr | output | 1 | Write strobe |
| rf_wdata | output | 8 | Write data |

## Verification
The bench builds the unit with its default parameters: a 4-bit bank field, the access split at 0x80 and the indexed limit at 0x5F. These defaults make the bottom bank, the top bank and both sides of the indexed boundary (0x5F against 0x60) reachable with single instructions. With the 12-bit index, an index near 0xFFF pushes the indexed sum past the top of the address space, which exercises the wraparound. Each bit position from 0 to 7 is set at least once, and one run changes the bank and index inputs in the middle of an instruction.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    localparam int F_W    = 8;
    localparam int BIT_W  = 3;
    localparam int DATA_W = 8;
    localparam int INSTR_W = 16;
    localparam logic [3:0] OPC_BITSET = 4'b1000;

    typedef enum logic [3:0] {
        PH_Q1 = 4'b0001,
        PH_Q2 = 4'b0010,
        PH_Q3 = 4'b0100,
        PH_Q4 = 4'b1000
    } phase_e;

    typedef enum logic [1:0] {
        AM_BANKED  = 2'd0,
        AM_ACCESS  = 2'd1,
        AM_INDEXED = 2'd2
    } amode_e;

    typedef struct packed {
        logic             hit;
        logic [BIT_W-1:0] bitno;
        logic             acc_n;
        logic [F_W-1:0]   faddr;
    } bsf_fields_t;

    function automatic logic [DATA_W-1:0] bit_mask(input logic [BIT_W-1:0] b);
        logic [DATA_W-1:0] m;
        m = '0;
        m[b] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/bsf_phase_gen.sv
module bsf_phase_gen
    import bsf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_Q1;
        end else begin
            unique case (phase_q)
                PH_Q1:   phase_q <= PH_Q2;
                PH_Q2:   phase_q <= PH_Q3;
                PH_Q3:   phase_q <= PH_Q4;
                default: phase_q <= PH_Q1;
            endcase
        end
    end

    assign phase = phase_q;

    // R1
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_q) == 1);

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_Q4) |=> (phase_q == PH_Q1));

endmodule

// File: rtl/bsf_decode.sv
module bsf_decode
    import bsf_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output bsf_fields_t        fields
);
    always_comb begin
        fields.hit   = (word[15:12] == OPC_BITSET);
        fields.bitno = word[11:9];
        fields.acc_n = word[8];
        fields.faddr = word[7:0];
    end
endmodule

// File: rtl/bsf_addr_resolve.sv
module bsf_addr_resolve
    import bsf_pkg::*;
#(
    parameter int          BANK_W    = 4,
    parameter logic [7:0]  ACC_SPLIT = 8'h80,
    parameter logic [7:0]  IDX_MAX   = 8'h5F,
    localparam int         ADDR_W    = BANK_W + F_W
)(
    input  bsf_fields_t       fields,
    input  logic [BANK_W-1:0] bank,
    input  logic              ext,
    input  logic [ADDR_W-1:0] index,
    output amode_e            mode,
    output logic [ADDR_W-1:0] eaddr
);
    logic [ADDR_W-1:0] f_ext;
    logic [ADDR_W-1:0] idx_sum;
    logic [ADDR_W-1:0] acc_addr;

    assign f_ext   = {{BANK_W{1'b0}}, fields.faddr};
    assign idx_sum = index + f_ext;

    always_comb begin
        if (fields.faddr >= ACC_SPLIT)
            acc_addr = {{BANK_W{1'b1}}, fields.faddr};
        else
            acc_addr = f_ext;
    end

    always_comb begin
        if (fields.acc_n)
            mode = AM_BANKED;
        else if (ext && (fields.faddr <= IDX_MAX))
            mode = AM_INDEXED;
        else
            mode = AM_ACCESS;
    end

    always_comb begin
        unique case (mode)
            AM_BANKED:  eaddr = {bank, fields.faddr};
            AM_INDEXED: eaddr = idx_sum;
            default:    eaddr = acc_addr;
        endcase
    end
endmodule

// File: rtl/bsf_merge.sv
module bsf_merge
    import bsf_pkg::*;
(
    input  logic [DATA_W-1:0] rd_byte,
    input  logic [BIT_W-1:0]  bitno,
    output logic [DATA_W-1:0] wr_byte
);
    assign wr_byte = rd_byte | bit_mask(bitno);
endmodule

// File: rtl/bsf_rmw_unit.sv
module bsf_rmw_unit
    import bsf_pkg::*;
#(
    parameter int          BANK_W    = 4,
    parameter logic [7:0]  ACC_SPLIT = 8'h80,
    parameter logic [7:0]  IDX_MAX   = 8'h5F,
    localparam int         ADDR_W    = BANK_W + 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       instr_word,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              ext_en,
    input  logic [ADDR_W-1:0] index_base,
    output logic [3:0]        qphase,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_rd,
    input  logic [7:0]        rf_rdata,
    output logic              rf_wr,
    output logic [7:0]        rf_wdata
);
    phase_e            phase;
    bsf_fields_t       dec_fields;
    bsf_fields_t       fields_q;
    amode_e            mode_c;
    amode_e            mode_q;
    logic [ADDR_W-1:0] ea_c;
    logic [ADDR_W-1:0] ea_q;
    logic [DATA_W-1:0] merged_c;
    logic [DATA_W-1:0] wdata_q;

    bsf_phase_gen u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    bsf_decode u_dec (
        .word   (instr_word),
        .fields (dec_fields)
    );

    bsf_addr_resolve #(
        .BANK_W    (BANK_W),
        .ACC_SPLIT (ACC_SPLIT),
        .IDX_MAX   (IDX_MAX)
    ) u_addr (
        .fields (dec_fields),
        .bank   (bank_sel),
        .ext    (ext_en),
        .index  (index_base),
        .mode   (mode_c),
        .eaddr  (ea_c)
    );

    bsf_merge u_merge (
        .rd_byte (rf_rdata),
        .bitno   (fields_q.bitno),
        .wr_byte (merged_c)
    );

    // Q1: capture decoded fields and the resolved address
    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= '0;
            mode_q   <= AM_BANKED;
            ea_q     <= '0;
        end else if (phase == PH_Q1) begin
            fields_q <= dec_fields;
            mode_q   <= mode_c;
            ea_q     <= ea_c;
        end
    end

    // Q3: latch the modified byte
    always_ff @(posedge clk) begin
        if (rst)
            wdata_q <= '0;
        else if (phase == PH_Q3)
            wdata_q <= merged_c;
    end

    assign qphase   = phase;
    assign rf_addr  = ea_q;
    assign rf_rd    = !rst && fields_q.hit && (phase == PH_Q2);
    assign rf_wr    = !rst && fields_q.hit && (phase == PH_Q4);
    assign rf_wdata = wdata_q;

    // R3
    rd_in_q2_chk: assert property (@(posedge clk) disable iff (rst)
        rf_rd |-> (qphase == 4'b0010));

    // R4
    wr_in_q4_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr |-> (qphase == 4'b1000));

    // R4
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr |-> $past(rf_rd, 2));

    // R5
    keep_bits_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr |-> ((rf_wdata & $past(rf_rdata)) == $past(rf_rdata)));

    // R5
    one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr |-> ($countones(rf_wdata ^ $past(rf_rdata)) <= 1));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr |-> (rf_addr == $past(rf_addr, 2)));

    // R10
    quiet_reset_chk: assert property (@(posedge clk)
        rst |-> (!rf_rd && !rf_wr));

endmodule

// File: tb/bsf_rmw_unit_test.sv
module bsf_rmw_unit_test;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [15:0]   instr_word;
    logic [3:0]    bank_sel;
    logic          ext_en;
    logic [AW-1:0] index_base;
    logic [3:0]    qphase;
    logic [AW-1:0] rf_addr;
    logic          rf_rd;
    logic [7:0]    rf_rdata;
    logic          rf_wr;
    logic [7:0]    rf_wdata;

    always #10 clk = ~clk;

    bsf_rmw_unit uut (
        .clk        (clk),
        .rst        (rst),
        .instr_word (instr_word),
        .bank_sel   (bank_sel),
        .ext_en     (ext_en),
        .index_base (index_base),
        .qphase     (qphase),
        .rf_addr    (rf_addr),
        .rf_rd      (rf_rd),
        .rf_rdata   (rf_rdata),
        .rf_wr      (rf_wr),
        .rf_wdata   (rf_wdata)
    );

    logic [7:0] mem  [0:4095];
    logic [7:0] refm [0:4095];

    always @(posedge clk) begin
        if (rf_rd) rf_rdata <= mem[rf_addr];
        if (rf_wr) mem[rf_addr] <= rf_wdata;
    end

    typedef struct {
        logic          wr;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        string         req;
    } item_t;

    item_t sb[$];
    int    n_tot = 0;
    int    n_bad = 0;
    bit    done  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] model_addr(input logic [15:0] w,
            input logic [3:0] bs, input logic ex, input logic [AW-1:0] ix);
        logic [7:0] f;
        f = w[7:0];
        if (w[8])                     return {bs, f};
        else if (ex && f <= 8'h5F)    return ix + {4'h0, f};
        else if (f >= 8'h80)          return {4'hF, f};
        else                          return {4'h0, f};
    endfunction

    // driver: one instruction per four-phase cycle
    task automatic run(input logic [15:0] w, input logic [3:0] bs, input logic ex,
                       input logic [AW-1:0] ix, input string req, input bit disturb);
        item_t it;
        logic [AW-1:0] a;
        do @(negedge clk); while (!qphase[0] || rst);
        a       = model_addr(w, bs, ex, ix);
        it.wr   = (w[15:12] == 4'b1000);
        it.addr = a;
        it.data = refm[a] | (8'h01 << w[11:9]);
        it.req  = req;
        if (it.wr) refm[a] = it.data;
        sb.push_back(it);
        instr_word = w; bank_sel = bs; ext_en = ex; index_base = ix;
        @(negedge clk);
        instr_word = 16'h0000;
        if (disturb) begin
            bank_sel   = ~bs;
            ext_en     = ~ex;
            index_base = ix + 12'h123;
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && qphase[1]) begin
                if (sb.size() > 0) begin
                    chk(rf_rd == sb[0].wr, {sb[0].req, " R3"}, "rd strobe in Q2", rf_rd, sb[0].wr);
                    if (sb[0].wr)
                        chk(rf_addr == sb[0].addr, sb[0].req, "Q2 address", rf_addr, sb[0].addr);
                end else if (rf_rd) begin
                    chk(0, "R3", "idle read", rf_rd, 0);
                end
            end
            if (!rst && qphase[3]) begin
                if (sb.size() > 0) begin
                    item_t it;
                    it = sb.pop_front();
                    chk(rf_wr == it.wr, {it.req, " R4"}, "wr strobe in Q4", rf_wr, it.wr);
                    if (it.wr) begin
                        chk(rf_addr == it.addr, it.req, "Q4 address", rf_addr, it.addr);
                        chk(rf_wdata == it.data, {it.req, " R5"}, "write data", rf_wdata, it.data);
                    end
                end else if (rf_wr) begin
                    chk(0, "R4", "idle write", rf_wr, 0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(0, "WDOG", "run did not finish", 0, 1);
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i]  = 8'((i * 37) ^ (i >> 4));
            refm[i] = mem[i];
        end
        mem[12'h30A] = 8'h0A; refm[12'h30A] = 8'h0A;
        mem[12'h345] = 8'h10; refm[12'h345] = 8'h10;
        rst = 1'b1; instr_word = 16'h0000; bank_sel = 4'h0; ext_en = 1'b0;
        index_base = '0;
        repeat (3) @(negedge clk);
        // R10 / R1: reset values
        chk(qphase == 4'b0001, "R1", "phase in reset", qphase, 1);
        chk(!rf_rd, "R10", "rd in reset", rf_rd, 0);
        chk(!rf_wr, "R10", "wr in reset", rf_wr, 0);
        rst = 1'b0;
        // R1: phase rotation
        @(negedge clk); chk(qphase == 4'b0010, "R1", "phase Q2", qphase, 2);
        @(negedge clk); chk(qphase == 4'b0100, "R1", "phase Q3", qphase, 4);
        @(negedge clk); chk(qphase == 4'b1000, "R1", "phase Q4", qphase, 8);
        @(negedge clk); chk(qphase == 4'b0001, "R1", "phase Q1", qphase, 1);

        // R6 / R5: banked, 0x0A bit 7 -> 0x8A
        run({4'b1000, 3'd7, 1'b1, 8'h0A}, 4'h3, 1'b0, 12'h000, "R6", 0);
        // R7: access bank low and high
        run({4'b1000, 3'd2, 1'b0, 8'h20}, 4'h5, 1'b0, 12'h000, "R7", 0);
        run({4'b1000, 3'd4, 1'b0, 8'h90}, 4'h5, 1'b0, 12'h000, "R7", 0);
        run({4'b1000, 3'd0, 1'b0, 8'h7F}, 4'h5, 1'b0, 12'h000, "R7", 0);
        run({4'b1000, 3'd1, 1'b0, 8'h80}, 4'h5, 1'b0, 12'h000, "R7", 0);
        // R8: indexed boundary and wraparound
        run({4'b1000, 3'd3, 1'b0, 8'h5F}, 4'h2, 1'b1, 12'h100, "R8", 0);
        run({4'b1000, 3'd3, 1'b0, 8'h60}, 4'h2, 1'b1, 12'h100, "R8", 0);
        run({4'b1000, 3'd6, 1'b0, 8'h20}, 4'h2, 1'b1, 12'hFF0, "R8", 0);
        run({4'b1000, 3'd5, 1'b0, 8'h00}, 4'h2, 1'b1, 12'h7A0, "R8", 0);
        // R6: extended mode does not affect banked access
        run({4'b1000, 3'd5, 1'b1, 8'h10}, 4'h9, 1'b1, 12'h400, "R6", 0);
        // R5: bit already set stays unchanged
        run({4'b1000, 3'd4, 1'b1, 8'h45}, 4'h3, 1'b0, 12'h000, "R5", 0);
        // R2 / R4: other opcodes do nothing
        run({4'b1001, 3'd7, 1'b1, 8'h0A}, 4'h3, 1'b0, 12'h000, "R2", 0);
        run({4'b0000, 3'd1, 1'b0, 8'h22}, 4'h0, 1'b0, 12'h000, "R4", 0);
        run({4'b1100, 3'd2, 1'b0, 8'h22}, 4'h0, 1'b1, 12'h000, "R4", 0);
        // R9: inputs disturbed after Q1
        run({4'b1000, 3'd1, 1'b1, 8'h33}, 4'h6, 1'b0, 12'h000, "R9", 1);
        run({4'b1000, 3'd2, 1'b0, 8'h11}, 4'h6, 1'b1, 12'h200, "R9", 1);
        // R2 / R5: every bit position on one byte
        for (int b = 0; b < 8; b++)
            run({4'b1000, 3'(b), 1'b1, 8'hC4}, 4'hA, 1'b0, 12'h000, "R2", 0);

        do @(negedge clk); while (sb.size() > 0);
        repeat (4) @(negedge clk);
        // R4 / R5: full memory compare against the reference copy
        begin
            int mism;
            mism = 0;
            for (int i = 0; i < 4096; i++) begin
                if (mem[i] !== refm[i]) begin
                    mism++;
                    chk(0, "R4", $sformatf("memory @%0h", i), mem[i], refm[i]);
                end
            end
            chk(mism == 0, "R4", "memory mismatches", mism, 0);
        end
        chk(mem[12'hAC4] == 8'hFF, "R5", "all bits set", mem[12'hAC4], 8'hFF);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

endmodule